// File: doc/BRIEF.md
# Local/Remote Address Bridge

The bridge sits beside a node's memory bus and splits global physical addresses by their node field. An access whose node field equals this node's identifier is steered straight to the local memory port in the same cycle. An access naming any other node is answered by the bridge in place of memory: it builds a request packet for the target node, sends it on the network output port, and holds the bus until the matching response comes back.

The bridge also works in the opposite direction. When a request packet arrives from another node, it performs the read or write on the local memory port itself. It then returns a response packet to the requester. The bridge therefore acts as a stand-in memory for outgoing remote traffic and as a stand-in processor for incoming traffic, both at the same time.

Addresses reaching the bridge are already translated. The upper `NODE_W` bits are the node number and the lower `OFS_W` bits are the offset inside that node's memory. Only one remote bus access is in flight at any time.

Top module: `node_mem_bridge`

## Requirements
- R1: When `bus_req_i` is high, the bridge is idle, the node field `bus_addr_i[31:24]` equals `node_id_i`, and no incoming request is being accepted in that cycle, the bridge does the following in that same cycle: it drives `mem_req_o` high with `mem_we_o`=`bus_we_i`, `mem_addr_o`=`bus_addr_i[23:0]` and `mem_wdata_o`=`bus_wdata_i`; it raises `bus_rdy_o`; and it returns `mem_rdata_i` on `bus_rdata_o`. No packet is sent for a local access.
- R2: A bus access to another node produces exactly one packet on the network output with these fields: `tx_resp_o`=0, `tx_write_o`=`bus_we_i`, `tx_dst_o`=`bus_addr_i[31:24]`, `tx_src_o`=`node_id_i`, `tx_ofs_o`=`bus_addr_i[23:0]` and `tx_data_o`=`bus_wdata_i`.
- R3: For a remote access, `bus_rdy_o` stays low until a response packet (`rx_resp_i`=1) is accepted. It rises in the cycle after that acceptance, with `bus_rdata_o` equal to the response's `rx_data_i`.
- R4: At most one outgoing request is outstanding. No new request packet leaves until the bus access that sent the previous one has completed.
- R5: An incoming request packet (`rx_resp_i`=0) is carried out on the memory port in the cycle it is accepted. In that cycle `mem_req_o`=1, `mem_we_o`=`rx_write_i`, `mem_addr_o`=`rx_ofs_i` and `mem_wdata_o`=`rx_data_i`.
- R6: Each accepted incoming request produces one response packet with these fields: `tx_resp_o`=1, `tx_write_o` equal to the request's write flag, `tx_dst_o` equal to the request's `rx_src_i`, `tx_src_o`=`node_id_i`, and `tx_ofs_o` equal to the request offset. `tx_data_o` carries the memory word read at acceptance for a read, and zero for a write acknowledge.
- R7: Incoming requests win the memory port. When the incoming side is free and an incoming request is valid, it is accepted (`rx_ready_o`=1), and a local bus access in that cycle is stalled with `bus_rdy_o`=0.
- R8: When a response is waiting and no outgoing packet is part-way through a handshake, the response is sent before any pending request packet.
- R9: A packet transfers only when valid and ready are both high. While `tx_valid_o` is high and `tx_ready_i` is low, the packet and its valid stay unchanged in the next cycle.
- R10: While a response is still waiting to be sent, no further incoming request is accepted (`rx_ready_o`=0 when `rx_resp_i`=0).
- R11: During reset `tx_valid_o` and `mem_req_o` are low and `bus_rdy_o` is low with no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | NODE_W | Identifier of this node |
| bus_req_i | input | 1 | Bus access request, held until ready |
| bus_we_i | input | 1 | Bus access is a write |
| bus_addr_i | input | NODE_W+OFS_W | Global physical address |
| bus_wdata_i | input | DATA_W | Bus write data |
| bus_rdy_o | output | 1 | Bus access completes this cycle |
| bus_rdata_o | output | DATA_W | Bus read data, valid with ready |
| mem_req_o | output | 1 | Local memory access strobe |
| mem_we_o | output | 1 | Local memory write enable |
| mem_addr_o | output | OFS_W | Local memory offset |
| mem_wdata_o | output | DATA_W | Local memory write data |
| mem_rdata_i | input | DATA_W | Local memory read data, same cycle |
| tx_valid_o | output | 1 | Outgoing packet valid |
| tx_ready_i | input | 1 | Network accepts outgoing packet |
| tx_resp_o | output | 1 | Outgoing packet is a response |
| tx_write_o | output | 1 | Outgoing packet concerns a write |
| tx_dst_o | output | NODE_W | Destination node |
| tx_src_o | output | NODE_W | Source node |
| tx_ofs_o | output | OFS_W | Offset in destination memory |
| tx_data_o | output | DATA_W | Write data or read data |
| rx_valid_i | input | 1 | Incoming packet valid |
| rx_ready_o | output | 1 | Bridge accepts incoming packet |
| rx_resp_i | input | 1 | Incoming packet is a response |
| rx_write_i | input | 1 | Incoming packet concerns a write |
| rx_src_i | input | NODE_W | Node that sent the packet |
| rx_ofs_i | input | OFS_W | Offset in this node's memory |
| rx_data_i | input | DATA_W | Write data or read data |

## Verification
The bench builds the bridge with its default widths: an 8-bit node field, a 24-bit offset and 32-bit data. It uses node identifier 0x05. With these values, the two extreme node numbers 0x00 and 0xFF can both be used as remote targets. Offsets at the top of the 24-bit range alias onto a 64-word bench memory, so the full offset width is driven and checked without a large array. Random stalls on the transmit ready, combined with overlapping local, remote and incoming traffic, create the port contention, the response-first choice and the held-packet cases.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    OB_IDLE = 2'd0,
    OB_SEND = 2'd1,
    OB_WAIT = 2'd2,
    OB_DONE = 2'd3
  } ob_state_e;

  typedef enum logic {
    IB_IDLE = 1'b0,
    IB_RESP = 1'b1
  } ib_state_e;
endpackage

// File: rtl/bridge_outbound.sv
module bridge_outbound
  import bridge_pkg::*;
#(
  parameter int NODE_W = 8,
  parameter int OFS_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NODE_W-1:0]       node_id_i,
  input  logic                    bus_req_i,
  input  logic                    bus_we_i,
  input  logic [NODE_W+OFS_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  input  logic                    port_busy_i,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  input  logic                    req_gnt_i,
  input  logic                    rsp_valid_i,
  input  logic [DATA_W-1:0]       rsp_data_i,
  output logic                    bus_rdy_o,
  output logic [DATA_W-1:0]       bus_rdata_o,
  output logic                    loc_req_o,
  output logic                    req_valid_o,
  output logic                    req_write_o,
  output logic [NODE_W-1:0]       req_dst_o,
  output logic [OFS_W-1:0]        req_ofs_o,
  output logic [DATA_W-1:0]       req_data_o,
  output logic                    rsp_ready_o
);
  localparam int ADDR_W = NODE_W + OFS_W;

  ob_state_e         state_q, state_d;
  logic              wr_q;
  logic [NODE_W-1:0] dst_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              is_local, start_remote;

  assign is_local     = bus_addr_i[ADDR_W-1:OFS_W] == node_id_i;
  assign start_remote = (state_q == OB_IDLE) && bus_req_i && !is_local;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OB_IDLE: if (start_remote) state_d = OB_SEND;
      OB_SEND: if (req_gnt_i) state_d = OB_WAIT;
      OB_WAIT: if (rsp_valid_i) state_d = OB_DONE;
      OB_DONE: state_d = OB_IDLE;
      default: state_d = OB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OB_IDLE;
      wr_q    <= 1'b0;
      dst_q   <= '0;
      ofs_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_remote) begin
        wr_q    <= bus_we_i;
        dst_q   <= bus_addr_i[ADDR_W-1:OFS_W];
        ofs_q   <= bus_addr_i[OFS_W-1:0];
        wdata_q <= bus_wdata_i;
      end
      if (state_q == OB_WAIT && rsp_valid_i) rdata_q <= rsp_data_i;
    end
  end

  // local path shares the port; incoming work has precedence
  assign loc_req_o   = (state_q == OB_IDLE) && bus_req_i && is_local && !port_busy_i;
  assign bus_rdy_o   = loc_req_o || (state_q == OB_DONE);
  assign bus_rdata_o = (state_q == OB_DONE) ? rdata_q : mem_rdata_i;
  assign req_valid_o = state_q == OB_SEND;
  assign req_write_o = wr_q;
  assign req_dst_o   = dst_q;
  assign req_ofs_o   = ofs_q;
  assign req_data_o  = wdata_q;
  assign rsp_ready_o = state_q == OB_WAIT;
endmodule

// File: rtl/bridge_inbound.sv
module bridge_inbound
  import bridge_pkg::*;
#(
  parameter int NODE_W = 8,
  parameter int OFS_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_resp_i,
  input  logic              rx_write_i,
  input  logic [NODE_W-1:0] rx_src_i,
  input  logic [OFS_W-1:0]  rx_ofs_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              rsp_gnt_i,
  output logic              req_ready_o,
  output logic              take_o,
  output logic              rsp_valid_o,
  output logic              rsp_write_o,
  output logic [NODE_W-1:0] rsp_dst_o,
  output logic [OFS_W-1:0]  rsp_ofs_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  ib_state_e         state_q;
  logic              wr_q;
  logic [NODE_W-1:0] dst_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_q;

  assign req_ready_o = state_q == IB_IDLE;
  assign take_o      = req_ready_o && rx_valid_i && !rx_resp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= IB_IDLE;
      wr_q    <= 1'b0;
      dst_q   <= '0;
      ofs_q   <= '0;
      data_q  <= '0;
    end else if (take_o) begin
      state_q <= IB_RESP;
      wr_q    <= rx_write_i;
      dst_q   <= rx_src_i;
      ofs_q   <= rx_ofs_i;
      data_q  <= rx_write_i ? '0 : mem_rdata_i;
    end else if (state_q == IB_RESP && rsp_gnt_i) begin
      state_q <= IB_IDLE;
    end
  end

  assign rsp_valid_o = state_q == IB_RESP;
  assign rsp_write_o = wr_q;
  assign rsp_dst_o   = dst_q;
  assign rsp_ofs_o   = ofs_q;
  assign rsp_data_o  = data_q;
endmodule

// File: rtl/bridge_tx_arb.sv
module bridge_tx_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic rsp_valid_i,
  input  logic tx_ready_i,
  output logic tx_valid_o,
  output logic sel_rsp_o,
  output logic req_gnt_o,
  output logic rsp_gnt_o
);
  logic hold_q, hold_rsp_q;

  // a packet already offered stays selected until taken
  assign sel_rsp_o  = hold_q ? hold_rsp_q : rsp_valid_i;
  assign tx_valid_o = sel_rsp_o ? rsp_valid_i : req_valid_i;
  assign rsp_gnt_o  = tx_valid_o && tx_ready_i && sel_rsp_o;
  assign req_gnt_o  = tx_valid_o && tx_ready_i && !sel_rsp_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      hold_rsp_q <= 1'b0;
    end else begin
      hold_q     <= tx_valid_o && !tx_ready_i;
      hold_rsp_q <= sel_rsp_o;
    end
  end
endmodule

// File: rtl/node_mem_bridge.sv
module node_mem_bridge #(
  parameter int NODE_W = 8,
  parameter int OFS_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NODE_W-1:0]       node_id_i,
  input  logic                    bus_req_i,
  input  logic                    bus_we_i,
  input  logic [NODE_W+OFS_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic                    bus_rdy_o,
  output logic [DATA_W-1:0]       bus_rdata_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [OFS_W-1:0]        mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic                    tx_valid_o,
  input  logic                    tx_ready_i,
  output logic                    tx_resp_o,
  output logic                    tx_write_o,
  output logic [NODE_W-1:0]       tx_dst_o,
  output logic [NODE_W-1:0]       tx_src_o,
  output logic [OFS_W-1:0]        tx_ofs_o,
  output logic [DATA_W-1:0]       tx_data_o,
  input  logic                    rx_valid_i,
  output logic                    rx_ready_o,
  input  logic                    rx_resp_i,
  input  logic                    rx_write_i,
  input  logic [NODE_W-1:0]       rx_src_i,
  input  logic [OFS_W-1:0]        rx_ofs_i,
  input  logic [DATA_W-1:0]       rx_data_i
);
  logic              ib_take, ib_ready, ob_loc;
  logic              ob_req_valid, ob_req_write, ob_rsp_ready;
  logic [NODE_W-1:0] ob_req_dst;
  logic [OFS_W-1:0]  ob_req_ofs;
  logic [DATA_W-1:0] ob_req_data;
  logic              ib_rsp_valid, ib_rsp_write;
  logic [NODE_W-1:0] ib_rsp_dst;
  logic [OFS_W-1:0]  ib_rsp_ofs;
  logic [DATA_W-1:0] ib_rsp_data;
  logic              sel_rsp, req_gnt, rsp_gnt;

  bridge_outbound #(.NODE_W(NODE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni, .node_id_i, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .port_busy_i (ib_take),
    .mem_rdata_i,
    .req_gnt_i   (req_gnt),
    .rsp_valid_i (rx_valid_i && rx_resp_i),
    .rsp_data_i  (rx_data_i),
    .bus_rdy_o, .bus_rdata_o,
    .loc_req_o   (ob_loc),
    .req_valid_o (ob_req_valid),
    .req_write_o (ob_req_write),
    .req_dst_o   (ob_req_dst),
    .req_ofs_o   (ob_req_ofs),
    .req_data_o  (ob_req_data),
    .rsp_ready_o (ob_rsp_ready)
  );

  bridge_inbound #(.NODE_W(NODE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_in (
    .clk_i, .rst_ni, .rx_valid_i, .rx_resp_i, .rx_write_i, .rx_src_i, .rx_ofs_i,
    .mem_rdata_i,
    .rsp_gnt_i   (rsp_gnt),
    .req_ready_o (ib_ready),
    .take_o      (ib_take),
    .rsp_valid_o (ib_rsp_valid),
    .rsp_write_o (ib_rsp_write),
    .rsp_dst_o   (ib_rsp_dst),
    .rsp_ofs_o   (ib_rsp_ofs),
    .rsp_data_o  (ib_rsp_data)
  );

  bridge_tx_arb u_arb (
    .clk_i, .rst_ni,
    .req_valid_i (ob_req_valid),
    .rsp_valid_i (ib_rsp_valid),
    .tx_ready_i,
    .tx_valid_o,
    .sel_rsp_o   (sel_rsp),
    .req_gnt_o   (req_gnt),
    .rsp_gnt_o   (rsp_gnt)
  );

  assign mem_req_o   = ib_take || ob_loc;
  assign mem_we_o    = ib_take ? rx_write_i : bus_we_i;
  assign mem_addr_o  = ib_take ? rx_ofs_i : bus_addr_i[OFS_W-1:0];
  assign mem_wdata_o = ib_take ? rx_data_i : bus_wdata_i;

  assign rx_ready_o  = rx_resp_i ? ob_rsp_ready : ib_ready;

  assign tx_resp_o   = sel_rsp;
  assign tx_write_o  = sel_rsp ? ib_rsp_write : ob_req_write;
  assign tx_dst_o    = sel_rsp ? ib_rsp_dst : ob_req_dst;
  assign tx_src_o    = node_id_i;
  assign tx_ofs_o    = sel_rsp ? ib_rsp_ofs : ob_req_ofs;
  assign tx_data_o   = sel_rsp ? ib_rsp_data : ob_req_data;
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int NODE_W = 8,
  parameter int OFS_W  = 24,
  parameter int DATA_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NODE_W-1:0]       node_id_i,
  input logic                    bus_req_i,
  input logic                    bus_we_i,
  input logic [NODE_W+OFS_W-1:0] bus_addr_i,
  input logic                    bus_rdy_o,
  input logic                    mem_req_o,
  input logic                    mem_we_o,
  input logic [OFS_W-1:0]        mem_addr_o,
  input logic                    tx_valid_o,
  input logic                    tx_ready_i,
  input logic                    tx_resp_o,
  input logic                    tx_write_o,
  input logic [NODE_W-1:0]       tx_dst_o,
  input logic [OFS_W-1:0]        tx_ofs_o,
  input logic [DATA_W-1:0]       tx_data_o,
  input logic                    rx_valid_i,
  input logic                    rx_ready_o,
  input logic                    rx_resp_i,
  input logic [OFS_W-1:0]        rx_ofs_i
);
  logic bus_local, outstanding_q, pend_rsp_q, hold_req_q;

  assign bus_local = bus_addr_i[NODE_W+OFS_W-1:OFS_W] == node_id_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outstanding_q <= 1'b0;
      pend_rsp_q    <= 1'b0;
      hold_req_q    <= 1'b0;
    end else begin
      if (tx_valid_o && tx_ready_i && !tx_resp_o) outstanding_q <= 1'b1;
      else if (bus_req_i && bus_rdy_o && !bus_local) outstanding_q <= 1'b0;
      if (rx_valid_i && rx_ready_o && !rx_resp_i) pend_rsp_q <= 1'b1;
      else if (tx_valid_o && tx_ready_i && tx_resp_o) pend_rsp_q <= 1'b0;
      hold_req_q <= tx_valid_o && !tx_ready_i && !tx_resp_o;
    end
  end

  p_local_port_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && bus_rdy_o && bus_local |->
      mem_req_o && mem_we_o == bus_we_i && mem_addr_o == bus_addr_i[OFS_W-1:0]);

  p_rdy_after_rsp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && bus_rdy_o && !bus_local |-> $past(rx_valid_i && rx_ready_o && rx_resp_i));

  p_single_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_q |-> !(tx_valid_o && !tx_resp_o));

  p_inbound_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_ready_o && !rx_resp_i |->
      mem_req_o && mem_addr_o == rx_ofs_i && !(bus_rdy_o && bus_local));

  p_rsp_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_rsp_q && !hold_req_q |-> tx_valid_o && tx_resp_o);

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_resp_o) && $stable(tx_write_o)
      && $stable(tx_dst_o) && $stable(tx_ofs_o) && $stable(tx_data_o));

  p_one_inbound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_rsp_q |-> !(rx_ready_o && !rx_resp_i));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r11: assert (!tx_valid_o);
    end
  end
endmodule

bind node_mem_bridge bridge_checker #(.NODE_W(NODE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/node_mem_bridge_tb_top.sv
module node_mem_bridge_tb_top;
  localparam int NODE_W = 8;
  localparam int OFS_W  = 24;
  localparam int DATA_W = 32;
  localparam int WORDS  = 64;
  localparam logic [7:0] MY_NODE = 8'h05;

  typedef struct packed {
    logic        resp;
    logic        write;
    logic [7:0]  dst;
    logic [7:0]  src;
    logic [23:0] ofs;
    logic [31:0] data;
  } pkt_t;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
  } op_t;

  logic        clk, rst_ni;
  logic        bus_req, bus_we, bus_rdy;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_resp, tx_write;
  logic [7:0]  tx_dst, tx_src;
  logic [23:0] tx_ofs;
  logic [31:0] tx_data;
  logic        rx_valid, rx_ready, rx_resp, rx_write;
  logic [7:0]  rx_src;
  logic [23:0] rx_ofs;
  logic [31:0] rx_data;

  node_mem_bridge #(.NODE_W(NODE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .node_id_i(MY_NODE),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdy_o(bus_rdy), .bus_rdata_o(bus_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_resp_o(tx_resp), .tx_write_o(tx_write),
    .tx_dst_o(tx_dst), .tx_src_o(tx_src), .tx_ofs_o(tx_ofs), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_resp_i(rx_resp), .rx_write_i(rx_write),
    .rx_src_i(rx_src), .rx_ofs_i(rx_ofs), .rx_data_i(rx_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] mem [WORDS];
  logic [31:0] ref_mem [WORDS];
  assign mem_rdata = mem[mem_addr[5:0]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[5:0]] <= mem_wdata;

  int unsigned n_chk = 0, n_fail = 0;
  op_t  bus_q[$];
  pkt_t rx_q[$], exp_req[$], exp_rsp[$];
  bit   go = 0, bus_act = 0, rx_act = 0, resp_pend = 0, remote_sent = 0;
  bit   tx_hold_prev = 0, hold_req_prev = 0, rsp_hs_prev = 0;
  bit   rmt_pend = 0;
  int   rmt_cnt = 0;
  int   ready_mode = 0;
  op_t  cur;
  pkt_t rx_cur, rmt_pkt, tx_prev;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] remote_val(logic [7:0] n, logic [23:0] o);
    return {n, o} ^ 32'h5A5A_A5A5;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic pkt_t tx_pkt();
    return '{tx_resp, tx_write, tx_dst, tx_src, tx_ofs, tx_data};
  endfunction

  // cycle engine: drive at falling edge, sample 1 ns before rising edge
  initial begin
    wait (go);
    forever begin
      @(negedge clk);
      if (!bus_act && bus_q.size() > 0) begin
        cur = bus_q.pop_front();
        bus_act = 1;
        remote_sent = 0;
        if (cur.addr[31:24] != MY_NODE)
          exp_req.push_back('{1'b0, cur.we, cur.addr[31:24], MY_NODE, cur.addr[23:0], cur.wdata});
      end
      bus_req = bus_act; bus_we = cur.we; bus_addr = cur.addr; bus_wdata = cur.wdata;
      if (rmt_pend && rmt_cnt > 0) rmt_cnt--;
      if (!rx_act) begin
        if (rmt_pend && rmt_cnt == 0) begin
          rx_cur = rmt_pkt; rx_act = 1; rmt_pend = 0;
        end else if (rx_q.size() > 0) begin
          rx_cur = rx_q.pop_front(); rx_act = 1;
        end
      end
      rx_valid = rx_act; rx_resp = rx_cur.resp; rx_write = rx_cur.write;
      rx_src = rx_cur.src; rx_ofs = rx_cur.ofs; rx_data = rx_cur.data;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 2) ? 1'b0 : lfsr[0];
      #3;
      begin
        bit tx_hs, rx_hs, rsp_hs, req_take, loc;
        pkt_t p;
        p = tx_pkt();
        tx_hs = tx_valid && tx_ready;
        rx_hs = rx_act && rx_ready;
        rsp_hs = rx_hs && rx_cur.resp;
        req_take = rx_hs && !rx_cur.resp;
        if (tx_hold_prev) chk(tx_valid && p == tx_prev, "R9", "held packet", p, tx_prev);
        if (resp_pend && !hold_req_prev)
          chk(tx_valid && tx_resp, "R8", "response first", {tx_valid, tx_resp}, 2'b11);
        if (tx_hs) begin
          if (tx_resp) begin
            chk(exp_rsp.size() > 0 && p == exp_rsp[0], "R6", "response packet", p,
                exp_rsp.size() > 0 ? exp_rsp[0] : '0);
            if (exp_rsp.size() > 0) void'(exp_rsp.pop_front());
          end else begin
            chk(!remote_sent, "R4", "second request", 1, 0);
            chk(exp_req.size() > 0 && p == exp_req[0], "R2", "request packet", p,
                exp_req.size() > 0 ? exp_req[0] : '0);
            if (exp_req.size() > 0) void'(exp_req.pop_front());
            remote_sent = 1;
            rmt_pkt = '{1'b1, tx_write, MY_NODE, tx_dst, tx_ofs,
                        tx_write ? 32'h0 : remote_val(tx_dst, tx_ofs)};
            rmt_pend = 1; rmt_cnt = 1 + int'(lfsr[3:2]);
          end
        end
        if (rx_act && !rx_cur.resp) begin
          if (resp_pend) chk(!rx_ready, "R10", "second inbound accepted", rx_ready, 0);
          else begin
            chk(rx_ready, "R7", "inbound accept", rx_ready, 1);
            chk(mem_req && mem_we == rx_cur.write && mem_addr == rx_cur.ofs &&
                (!rx_cur.write || mem_wdata == rx_cur.data), "R5", "inbound port",
                {mem_req, mem_we, mem_addr}, {1'b1, rx_cur.write, rx_cur.ofs});
          end
        end
        if (req_take) begin
          exp_rsp.push_back('{1'b1, rx_cur.write, rx_cur.src, MY_NODE, rx_cur.ofs,
                              rx_cur.write ? 32'h0 : ref_mem[rx_cur.ofs[5:0]]});
          if (rx_cur.write) ref_mem[rx_cur.ofs[5:0]] = rx_cur.data;
        end
        if (bus_act) begin
          loc = cur.addr[31:24] == MY_NODE;
          if (loc) begin
            chk(bus_rdy == !req_take, "R1", "local ready", bus_rdy, !req_take);
            if (req_take) chk(!bus_rdy, "R7", "bus stalled by inbound", bus_rdy, 0);
            if (bus_rdy) begin
              chk(mem_req && mem_we == cur.we && mem_addr == cur.addr[23:0], "R1", "local port",
                  {mem_req, mem_we, mem_addr}, {1'b1, cur.we, cur.addr[23:0]});
              if (!cur.we) chk(bus_rdata == ref_mem[cur.addr[5:0]], "R1", "local read",
                               bus_rdata, ref_mem[cur.addr[5:0]]);
              else ref_mem[cur.addr[5:0]] = cur.wdata;
              bus_act = 0;
            end
          end else begin
            chk(bus_rdy == rsp_hs_prev, "R3", "remote ready timing", bus_rdy, rsp_hs_prev);
            if (bus_rdy) begin
              if (!cur.we) chk(bus_rdata == remote_val(cur.addr[31:24], cur.addr[23:0]), "R3",
                               "remote read", bus_rdata, remote_val(cur.addr[31:24], cur.addr[23:0]));
              bus_act = 0; remote_sent = 0;
            end
          end
        end else chk(!bus_rdy, "R3", "ready without request", bus_rdy, 0);
        if (rx_hs) rx_act = 0;
        if (req_take) resp_pend = 1;
        else if (tx_hs && tx_resp) resp_pend = 0;
        tx_hold_prev = tx_valid && !tx_ready;
        hold_req_prev = tx_hold_prev && !tx_resp;
        tx_prev = p;
        rsp_hs_prev = rsp_hs;
      end
    end
  end

  task automatic bus_op(bit we, logic [31:0] addr, logic [31:0] wd);
    bus_q.push_back('{we, addr, wd});
  endtask

  task automatic inbound(bit we, logic [7:0] src, logic [23:0] ofs, logic [31:0] d);
    rx_q.push_back('{1'b0, we, MY_NODE, src, ofs, d});
  endtask

  task automatic wait_idle();
    while (bus_act || rx_act || resp_pend || rmt_pend || bus_q.size() > 0 || rx_q.size() > 0 ||
           exp_req.size() > 0 || exp_rsp.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = 32'h1000_0000 + 32'(i * 3);
      ref_mem[i] = mem[i];
    end
    rst_ni = 0; bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 0; rx_resp = 0; rx_write = 0; rx_src = '0; rx_ofs = '0; rx_data = '0;
    tx_ready = 1; cur = '0; rx_cur = '0; rmt_pkt = '0; tx_prev = '0;
    repeat (3) @(negedge clk);
    #3;
    chk(!tx_valid && !mem_req && !bus_rdy, "R11", "reset outputs", {tx_valid, mem_req, bus_rdy}, 0);
    @(negedge clk);
    rst_ni = 1;
    go = 1;
    // local traffic, including a top-of-range offset
    bus_op(1, {MY_NODE, 24'h000003}, 32'hDEAD_0003);
    bus_op(0, {MY_NODE, 24'h000003}, 32'h0);
    bus_op(0, {MY_NODE, 24'h00003F}, 32'h0);
    bus_op(0, {MY_NODE, 24'hFFFFC1}, 32'h0);
    wait_idle();
    // remote traffic to extreme node numbers
    bus_op(0, {8'h07, 24'h123456}, 32'h0);
    bus_op(1, {8'h00, 24'h000005}, 32'hCAFE_0005);
    bus_op(0, {8'hFF, 24'hFFFFFF}, 32'h0);
    wait_idle();
    // incoming requests
    inbound(0, 8'h09, 24'h000003, 32'h0);
    inbound(1, 8'h0A, 24'h00000A, 32'hBEEF_000A);
    inbound(0, 8'hFF, 24'h00000A, 32'h0);
    wait_idle();
    // mixed traffic with random transmit stalls
    ready_mode = 1;
    for (int k = 0; k < 12; k++) begin
      bus_op(k[0], {MY_NODE, 24'(k * 5)}, 32'hA000_0000 + 32'(k));
      if (k % 3 == 0) bus_op(k[1], {8'(k + 1), 24'(k * 7)}, 32'hB000_0000 + 32'(k));
      inbound(k[2], 8'(k + 16), 24'(k * 5), 32'hC000_0000 + 32'(k));
    end
    wait_idle();
    // response and request compete with the output blocked
    ready_mode = 2;
    bus_op(0, {8'h21, 24'h000777}, 32'h0);
    inbound(0, 8'h33, 24'h000002, 32'h0);
    inbound(1, 8'h34, 24'h000004, 32'h1234_5678);
    repeat (6) @(negedge clk);
    ready_mode = 0;
    wait_idle();
    ready_mode = 1;
    for (int k = 0; k < 20; k++) begin
      bus_op(k[1], {(k[0] ? MY_NODE : 8'h40), 24'(k)}, 32'h7000_0000 + 32'(k));
      if (k[0]) inbound(k[2], 8'h50, 24'(63 - k), 32'h8000_0000 + 32'(k));
    end
    wait_idle();
    for (int i = 0; i < WORDS; i++)
      chk(mem[i] == ref_mem[i], "R5", "memory contents", mem[i], ref_mem[i]);
    report();
    $finish;
  end
endmodule